// File: doc/BRIEF.md
# Row-Buffered Page-Mode Memory Device Model

A clocked, synthesizable model of the device side of a byte-wide nonvolatile memory with page (row) access. Every strobe is active low and is sampled on the rising clock. When chip enable falls, the model opens a row: it latches the address and starts an access latency counter. The data bus is driven only after that latency has run out, and only while output enable is low and write enable is high. While chip enable stays low, a new value on the upper (row) address bits closes the current row and opens the new one by itself. A new value on the low (column) bits only reselects a byte inside the open row, which costs the shorter page latency.

Writes come in two kinds. A write whose write enable is already low when chip enable falls is chip-enable controlled. A write whose write enable falls later, inside an open row, is write-enable controlled. In both cases the byte is committed on the first sampled rise of either strobe, using the data present on that clock, and the kind is reported together with a one-cycle completion pulse. If chip enable is re-asserted before it has been high for the minimum precharge time, the model raises a one-cycle violation flag. A running count of row activations lets a bench check per-row endurance accounting. The array is `2**AW` bytes, and `AW=15` gives the full 32K x 8 organisation.

Top module: `rowbuf_mem`

## Requirements
- R1: After reset the bus is not driven, `row_opens` is 0, and `pc_viol` and `wr_done` are 0.
- R2: A sampled fall of `ce_n` latches `addr`, increments `row_opens` by one and starts a latency of `T_CE` clocks. With `oe_n` low and `we_n` high, `dout_oe` goes high `T_CE` clocks after that edge.
- R3: `dout_oe` stays low while the access latency is still counting, even with `oe_n` already low, and it stays low whenever `oe_n` is high.
- R4: Whenever `we_n` is low, `dout_oe` is low, whatever `oe_n` does.
- R5: While `ce_n` stays low, a change of `addr[AW-1:3]` opens the new row without any toggle of `ce_n`. It increments `row_opens` by one and delivers the new byte `T_AA` clocks later.
- R6: While `ce_n` stays low and the byte is already on the bus, a change of `addr[2:0]` alone leaves `row_opens` unchanged. The new byte is driven `T_PG` clocks later.
- R7: `pc_viol` pulses for one clock after a `ce_n` fall when `ce_n` was sampled high on fewer than `T_PC` consecutive clocks before it. Otherwise it stays 0.
- R8: A write stores `din`, as sampled on the clock where `we_n` or `ce_n` is first seen high, at the open address. A later read returns that byte.
- R9: `wr_done` pulses for one clock after each commit. With it, `wr_by_ce` is 1 if `we_n` was low at the opening `ce_n` fall, and 0 if the write began on a later `we_n` fall.
- R10: Inside one open row, successive `we_n` pulses at different column addresses each commit their own byte, and `row_opens` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Byte address; bits [2:0] select the column |
| din | input | DW | Write data |
| dout | output | DW | Read data at the open address |
| dout_oe | output | 1 | High when the device would drive the bus |
| wr_done | output | 1 | One-cycle pulse after a write commits |
| wr_by_ce | output | 1 | Write kind, valid with `wr_done` |
| pc_viol | output | 1 | One-cycle precharge violation pulse |
| row_opens | output | CW | Count of row activations |

## Verification
A row opened by `ce_n` is due on the bus `T_CE` clocks after the sampling edge. After a row-address change it is due `T_AA` clocks later, and after a column change `T_PG` clocks later. `wr_done`, `wr_by_ce`, `pc_viol` and `row_opens` change one clock after the edge that caused them. `dout_oe` also follows `we_n` and `oe_n` at once, within the same clock. Stimulus changes shortly after each rising edge. A behavioural reference model advances on the rising edge and is compared with every output at the falling edge, so each result is read in exactly the cycle it is due. Directed checks step these same windows one clock at a time. They confirm that the bus stays quiet for the full latency and turns on at the clock where it is due.

// File: rtl/rowbuf_mem.sv
module rowbuf_mem #(
  parameter int AW   = 11,
  parameter int DW   = 8,
  parameter int COLW = 3,
  parameter int CW   = 32,
  parameter int T_CE = 4,
  parameter int T_AA = 5,
  parameter int T_PG = 2,
  parameter int T_PC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  output logic          wr_done,
  output logic          wr_by_ce,
  output logic          pc_viol,
  output logic [CW-1:0] row_opens
);
  localparam int ROWW  = AW - COLW;
  localparam int DEPTH = 1 << AW;
  localparam int LMAX  = (T_CE > T_AA) ? ((T_CE > T_PG) ? T_CE : T_PG)
                                       : ((T_AA > T_PG) ? T_AA : T_PG);
  localparam int LW    = $clog2(LMAX + 1);
  localparam int PCW   = $clog2(T_PC + 2);

  logic [DW-1:0]   mem [DEPTH];
  logic            ce_d, open_q, wact_q, wce_q;
  logic [ROWW-1:0] row_q;
  logic [COLW-1:0] col_q;
  logic [LW-1:0]   lat_q;
  logic [PCW-1:0]  pc_q;
  logic            commit, row_chg, col_chg;
  logic [AW-1:0]   cur;

  assign cur     = {row_q, col_q};
  assign commit  = wact_q && (we_n || ce_n);
  assign row_chg = addr[AW-1:COLW] != row_q;
  assign col_chg = addr[COLW-1:0] != col_q;
  assign dout    = mem[cur];
  assign dout_oe = open_q && !ce_n && !oe_n && we_n && (lat_q == '0);

  always_ff @(posedge clk)
    if (commit) mem[cur] <= din;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_d      <= 1'b1;
      open_q    <= 1'b0;
      wact_q    <= 1'b0;
      wce_q     <= 1'b0;
      row_q     <= '0;
      col_q     <= '0;
      lat_q     <= '0;
      pc_q      <= PCW'(T_PC);
      wr_done   <= 1'b0;
      wr_by_ce  <= 1'b0;
      pc_viol   <= 1'b0;
      row_opens <= '0;
    end else begin
      ce_d    <= ce_n;
      wr_done <= 1'b0;
      pc_viol <= 1'b0;
      if (commit) begin
        wr_done  <= 1'b1;
        wr_by_ce <= wce_q;
        wact_q   <= 1'b0;
      end
      if (ce_n) begin
        open_q <= 1'b0;
        if (!ce_d)                    pc_q <= PCW'(1);
        else if (pc_q != PCW'(T_PC)) pc_q <= pc_q + PCW'(1);
      end else if (ce_d) begin
        open_q    <= 1'b1;
        row_q     <= addr[AW-1:COLW];
        col_q     <= addr[COLW-1:0];
        lat_q     <= LW'(T_CE);
        row_opens <= row_opens + CW'(1);
        pc_viol   <= pc_q < PCW'(T_PC);
        wact_q    <= !we_n;
        wce_q     <= !we_n;
      end else begin
        if (row_chg) begin
          row_q     <= addr[AW-1:COLW];
          col_q     <= addr[COLW-1:0];
          lat_q     <= LW'(T_AA);
          row_opens <= row_opens + CW'(1);
        end else if (col_chg) begin
          col_q <= addr[COLW-1:0];
          lat_q <= (lat_q == '0) ? LW'(T_PG) : lat_q - LW'(1);
        end else if (lat_q != '0) begin
          lat_q <= lat_q - LW'(1);
        end
        if (!we_n && !wact_q) begin
          wact_q <= 1'b1;
          wce_q  <= 1'b0;
        end
      end
    end
  end

  // R2
  row_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_opens != $past(row_opens)) |-> (row_opens == $past(row_opens) + CW'(1)));

  // R3
  no_drive_on_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_opens != $past(row_opens)) |-> !dout_oe);

  // R7
  viol_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_viol |-> (!$past(ce_n) && $past(ce_d)));

  // R9
  done_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> ($past(wact_q) && ($past(we_n) || $past(ce_n))));
endmodule

// File: tb/sim_rowbuf_mem.sv
module sim_rowbuf_mem;
  localparam int CLK  = 10;
  localparam int AW   = 11;
  localparam int T_CE = 4;
  localparam int T_AA = 5;
  localparam int T_PG = 2;
  localparam int T_PC = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic dout_oe, wr_done, wr_by_ce, pc_viol;
  logic [31:0] row_opens;
  int nchk = 0, nfail = 0;

  always #(CLK/2) clk = ~clk;

  rowbuf_mem #(.AW(AW), .DW(8), .COLW(3), .CW(32), .T_CE(T_CE), .T_AA(T_AA),
               .T_PG(T_PG), .T_PC(T_PC)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe), .wr_done(wr_done),
    .wr_by_ce(wr_by_ce), .pc_viol(pc_viol), .row_opens(row_opens));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [7:0] mem_m [int];
  int m_row, m_col, m_lat, m_pc, m_cnt;
  bit m_open, m_prev, m_wact, m_wce, m_wd, m_wbc, m_viol;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_open = 0; m_prev = 1; m_wact = 0; m_wce = 0; m_wd = 0; m_wbc = 0;
      m_viol = 0; m_pc = T_PC; m_cnt = 0; m_lat = 0; m_row = 0; m_col = 0;
    end else begin
      m_viol = 0; m_wd = 0;
      if (m_wact && (we_n || ce_n)) begin
        mem_m[m_row * 8 + m_col] = din;
        m_wd = 1; m_wbc = m_wce; m_wact = 0;
      end
      if (ce_n) begin
        m_open = 0;
        m_pc = !m_prev ? 1 : (m_pc < T_PC ? m_pc + 1 : T_PC);
      end else if (m_prev) begin
        m_open = 1; m_row = int'(addr) / 8; m_col = int'(addr) % 8;
        m_lat = T_CE; m_cnt++; m_viol = (m_pc < T_PC);
        m_wact = !we_n; m_wce = !we_n;
      end else begin
        if (int'(addr) / 8 != m_row) begin
          m_row = int'(addr) / 8; m_col = int'(addr) % 8; m_lat = T_AA; m_cnt++;
        end else if (int'(addr) % 8 != m_col) begin
          m_col = int'(addr) % 8;
          m_lat = (m_lat == 0) ? T_PG : m_lat - 1;
        end else if (m_lat > 0) m_lat--;
        if (!we_n && !m_wact) begin m_wact = 1; m_wce = 0; end
      end
      m_prev = ce_n;
    end
  end

  always @(negedge clk) if (rst_n) begin
    bit e_en;
    e_en = m_open && m_lat == 0 && !oe_n && we_n && !ce_n;
    chk(!we_n ? "R4 bus" : (oe_n ? "R3 bus" : "R2 bus"), dout_oe, e_en);
    if (e_en && mem_m.exists(m_row * 8 + m_col))
      chk("R6 data", dout, mem_m[m_row * 8 + m_col]);
    chk("R5 row count", row_opens, m_cnt);
    chk("R7 viol", pc_viol, m_viol);
    chk("R9 done", wr_done, m_wd);
    if (m_wd) chk("R9 kind", wr_by_ce, m_wbc);
  end

  task automatic tick;
    @(posedge clk); #2;
  endtask

  task automatic idle(int n);
    ce_n = 1; we_n = 1; oe_n = 1;
    repeat (n) tick;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R1 watchdog act=hung exp=done");
    finish_run;
  end

  localparam logic [AW-1:0] A1 = 11'h128, A2 = 11'h12D, A3 = 11'h3F2, PB = 11'h240;

  initial begin
    int base_cnt;
    repeat (4) tick;
    rst_n = 1; tick;
    chk("R1 oe", dout_oe, 0); chk("R1 count", row_opens, 0);
    chk("R1 viol", pc_viol, 0); chk("R1 done", wr_done, 0);

    // chip-enable controlled write to A1
    addr = A1; din = 8'hA5; we_n = 0; ce_n = 0; tick;
    chk("R2 opens", row_opens, 1);
    tick; tick;
    ce_n = 1; tick;
    chk("R9 ce done", wr_done, 1); chk("R9 ce kind", wr_by_ce, 1);
    idle(T_PC);

    // write-enable controlled writes to A2, then A3 via a row change
    addr = A2; ce_n = 0; tick; tick;
    din = 8'h3C; we_n = 0; tick;
    we_n = 1; tick;
    chk("R9 we done", wr_done, 1); chk("R9 we kind", wr_by_ce, 0);
    addr = A3; din = 8'h5A; we_n = 0; tick;
    we_n = 1; tick;
    chk("R5 count", row_opens, 3); chk("R8 done", wr_done, 1);
    idle(T_PC + 1);

    // read A1 with output enable early
    addr = A1; oe_n = 0; ce_n = 0; tick;
    repeat (T_CE) begin chk("R3 early", dout_oe, 0); tick; end
    chk("R2 latency", dout_oe, 1); chk("R8 data A1", dout, 8'hA5);

    // column change inside the open row
    addr = A2; tick;
    repeat (T_PG) begin chk("R6 wait", dout_oe, 0); tick; end
    chk("R6 on", dout_oe, 1); chk("R6 data", dout, 8'h3C); chk("R6 count", row_opens, 4);

    // write enable low blocks the bus
    din = 8'h3C; we_n = 0; #1;
    chk("R4 we low", dout_oe, 0);
    tick; chk("R4 we held", dout_oe, 0);
    we_n = 1; tick; tick;

    // row change with chip enable held low
    addr = A3; tick;
    chk("R5 reopen", row_opens, 5);
    repeat (T_AA) begin chk("R5 wait", dout_oe, 0); tick; end
    chk("R5 on", dout_oe, 1); chk("R5 data", dout, 8'h5A);

    // output enable high
    oe_n = 1;
    repeat (3) begin tick; chk("R3 oe high", dout_oe, 0); end
    ce_n = 1; tick;

    // precharge too short, then long enough
    ce_n = 0; tick;
    chk("R7 short", pc_viol, 1);
    tick; chk("R7 pulse", pc_viol, 0);
    idle(T_PC);
    ce_n = 0; tick;
    chk("R7 ok", pc_viol, 0);
    idle(T_PC);

    // page writes within one row
    addr = PB; ce_n = 0; tick;
    base_cnt = row_opens;
    for (int c = 0; c < 4; c++) begin
      addr = PB + AW'(c); din = 8'h10 + 8'(c); tick;
      we_n = 0; tick;
      we_n = 1; tick;
      chk("R10 done", wr_done, 1);
    end
    chk("R10 count", row_opens, base_cnt);
    oe_n = 0;
    for (int c = 3; c >= 0; c--) begin
      addr = PB + AW'(c);
      repeat (T_CE + 2) tick;
      chk("R10 oe", dout_oe, 1); chk("R10 data", dout, 8'h10 + 8'(c));
    end
    idle(4);
    finish_run;
  end
endmodule